// File: doc/BRIEF.md
# Exception Stack Sequencer

This block runs the stack traffic of an 8-bit processor core on the way into and out of exception handlers. It watches two request lines, one maskable and one non-maskable, and records a pending request whenever a line changes level. At each instruction boundary that the core marks, it decides whether to enter a handler. If no handler is entered, it may instead start one of the stack instructions that the core hands over: software break, status push, status pull or return from handler.

All three kinds of handler entry use one sequence. The sequence pushes a return address and a status byte into a fixed stack page, sets the interrupt-disable flag and then reads a two-byte handler address. Entries differ only in the return address, the break bit written into the pushed status and the vector location. The block owns the status byte and the 8-bit stack pointer. It reports the new program counter to the core when a sequence completes. Memory is reached through a byte-wide port with one access per cycle and a valid/ready handshake.

Top module: `intr_stack_seq`

## Requirements
- R1: A pending maskable request is taken only while status bit 2 (interrupt disable) is 0. A pending non-maskable request is taken whatever bit 2 holds.
- R2: At a boundary the maskable request is considered first. At most one entry starts per boundary, and a request that was not taken stays pending until a later boundary.
- R3: Stack accesses use addresses 0x0100 to 0x01FF. The stack pointer is used and then decremented for a push. It is incremented and then used for a pull. It wraps modulo 256.
- R4: An entry writes the return address high byte, then the low byte, then the status byte. After that it sets status bit 2.
- R5: A break entry pushes pc_in+2 with bit 4 of the pushed status set. A maskable or non-maskable entry pushes pc_in with bit 4 clear.
- R6: The maskable and break entries load new_pc from 0xFFFE (low) and 0xFFFF (high). The non-maskable entry loads it from 0xFFFA (low) and 0xFFFB (high).
- R7: With mem_ready held high, busy stays high for 7 cycles for any entry, 6 for return, 3 for status push and 4 for status pull. done pulses for one cycle after the last busy cycle.
- R8: Return pulls the status and forces bit 5 to 1. It then pulls the low byte and then the high byte of new_pc, and pulses pc_load.
- R9: Status push writes the status with bit 4 set. Status pull loads the pulled byte with bit 5 forced to 1. Neither one pulses pc_load.
- R10: req_lines bit 0 is the maskable line and bit 1 is the non-maskable line. On a level change, a line's pending flag takes the new level. The flag clears when its entry starts.
- R11: While mem_ready is low, the access in progress is held unchanged, and the stack pointer and status do not change.
- R12: After reset nothing is pending, the stack pointer is 0xFF, the status is 0x32 and busy is low.
- R13: op_code 0 is break, 1 is status push, 2 is status pull and 3 is return. An instruction starts only at a boundary with op_valid high and no entry taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_lines | input | 2 | Request lines: bit 0 maskable, bit 1 non-maskable |
| boundary | input | 1 | Instruction boundary strobe; valid only while busy is low |
| op_valid | input | 1 | A stack instruction is offered at this boundary |
| op_code | input | 2 | Offered instruction code |
| pc_in | input | 16 | Current program counter (address of the break opcode for a break) |
| mem_valid | output | 1 | Memory access requested |
| mem_write | output | 1 | Access is a write |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write data |
| mem_ready | input | 1 | Access completes this cycle |
| mem_rdata | input | 8 | Read data, valid with mem_ready |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse after a sequence ends |
| pc_load | output | 1 | With done: new_pc must be loaded |
| new_pc | output | 16 | Handler or return address |
| status | output | 8 | Processor status byte |
| sp | output | 8 | Stack pointer |

## Verification
Two things can arrive in the same boundary cycle: an entry decision and an offered stack instruction. A maskable and a non-maskable request can also both be pending. The bench raises both lines with the disable flag clear and offers a status push at the same boundary. It expects a maskable entry with three pushes and a clear break bit, with no push of the instruction. It then expects the non-maskable entry at the next boundary even though the disable flag is now set. Randomly ordered line changes, offered instructions and ready stalls are compared against a bench model of the stack page, pointer, status and pending flags.

// File: rtl/intr_stack_seq.sv
module intr_stack_seq #(
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] IRQ_VEC    = 16'hFFFE,
  parameter logic [15:0] NMI_VEC    = 16'hFFFA,
  parameter logic [7:0]  RST_STATUS = 8'h32,
  parameter logic [7:0]  RST_SP     = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  req_lines,
  input  logic        boundary,
  input  logic        op_valid,
  input  logic [1:0]  op_code,
  input  logic [15:0] pc_in,
  output logic        mem_valid,
  output logic        mem_write,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic        mem_ready,
  input  logic [7:0]  mem_rdata,
  output logic        busy,
  output logic        done,
  output logic        pc_load,
  output logic [15:0] new_pc,
  output logic [7:0]  status,
  output logic [7:0]  sp
);
  localparam logic [2:0] K_BRK = 3'd0, K_PHP = 3'd1, K_PLP = 3'd2, K_RTI = 3'd3,
                         K_IRQ = 3'd4, K_NMI = 3'd5;
  localparam logic [7:0] B_BIT = 8'h10, R_BIT = 8'h20;

  logic [1:0]  line_q, pend_q;
  logic        busy_q, done_q;
  logic [2:0]  kind_q, step_q;
  logic [15:0] ret_q, pc_q;
  logic [7:0]  sp_q, st_q;
  logic        acc, wr, last;

  wire entry    = (kind_q == K_BRK) || kind_q[2];
  wire take_irq = boundary && !busy_q && pend_q[0] && !st_q[2];
  wire take_nmi = boundary && !busy_q && !take_irq && pend_q[1];
  wire take_op  = boundary && !busy_q && !take_irq && !take_nmi && op_valid;
  wire adv      = busy_q && (!acc || mem_ready);
  wire [7:0] push_st = {st_q[7:5], (kind_q == K_BRK) || (kind_q == K_PHP), st_q[3:0]};
  wire [15:0] vec_base = (kind_q == K_NMI) ? NMI_VEC : IRQ_VEC;

  always_comb begin
    acc  = 1'b0;
    wr   = 1'b0;
    last = 1'b0;
    case (kind_q)
      K_PHP: begin acc = (step_q == 3'd1); wr = 1'b1; last = (step_q == 3'd2); end
      K_PLP: begin acc = (step_q == 3'd2); last = (step_q == 3'd3); end
      K_RTI: begin acc = (step_q >= 3'd2) && (step_q <= 3'd4); last = (step_q == 3'd5); end
      default: begin acc = (step_q >= 3'd2); wr = (step_q <= 3'd4); last = (step_q == 3'd6); end
    endcase
  end

  always_comb begin
    if (entry && !wr) mem_addr = vec_base + {15'd0, step_q == 3'd6};
    else if (wr)      mem_addr = {STACK_PAGE, sp_q};
    else              mem_addr = {STACK_PAGE, sp_q + 8'd1};
    if (entry && step_q == 3'd2)      mem_wdata = ret_q[15:8];
    else if (entry && step_q == 3'd3) mem_wdata = ret_q[7:0];
    else                              mem_wdata = push_st;
  end

  wire rd     = acc && !wr;
  wire rd_st  = rd && ((kind_q == K_PLP) || (kind_q == K_RTI && step_q == 3'd2));
  wire rd_lo  = rd && ((kind_q == K_RTI && step_q == 3'd3) || (entry && step_q == 3'd5));
  wire rd_hi  = rd && ((kind_q == K_RTI && step_q == 3'd4) || (entry && step_q == 3'd6));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= 2'b00;
      pend_q <= 2'b00;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      kind_q <= K_BRK;
      step_q <= 3'd0;
      ret_q  <= 16'd0;
      pc_q   <= 16'd0;
      sp_q   <= RST_SP;
      st_q   <= RST_STATUS;
    end else begin
      line_q <= req_lines;
      for (int i = 0; i < 2; i++)
        if (req_lines[i] != line_q[i]) pend_q[i] <= req_lines[i];
      if (take_irq) pend_q[0] <= 1'b0;
      if (take_nmi) pend_q[1] <= 1'b0;
      done_q <= 1'b0;
      if (take_irq || take_nmi || take_op) begin
        busy_q <= 1'b1;
        step_q <= 3'd0;
        kind_q <= take_irq ? K_IRQ : take_nmi ? K_NMI : {1'b0, op_code};
        ret_q  <= (take_op && op_code == 2'd0) ? pc_in + 16'd2 : pc_in;
      end else if (adv) begin
        step_q <= step_q + 3'd1;
        if (acc && wr) sp_q <= sp_q - 8'd1;
        if (rd && !entry) sp_q <= sp_q + 8'd1;
        if (entry && wr && step_q == 3'd4) st_q[2] <= 1'b1;
        if (rd_st) st_q <= mem_rdata | R_BIT;
        if (rd_lo) pc_q[7:0] <= mem_rdata;
        if (rd_hi) pc_q[15:8] <= mem_rdata;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign mem_valid = busy_q && acc;
  assign mem_write = wr;
  assign busy      = busy_q;
  assign done      = done_q;
  assign pc_load   = done_q && (entry || kind_q == K_RTI);
  assign new_pc    = pc_q;
  assign status    = st_q;
  assign sp        = sp_q;

  assert_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && step_q == 3'd0 && kind_q == K_IRQ) |-> !$past(st_q[2]));
  assert_pend_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy_q) && kind_q == K_NMI) |-> !pend_q[1]);
  assert_push_sp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write && mem_ready) |=> (sp_q == $past(sp_q) - 8'd1));
  assert_stack_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write) |-> (mem_addr[15:8] == STACK_PAGE));
  assert_disable_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && entry) |-> st_q[2]);
  assert_bit5_R8: assert property (@(posedge clk) disable iff (!rst_n) st_q[5]);
  assert_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_write && mem_addr[15:8] != STACK_PAGE) |-> (mem_addr[15:1] == vec_base[15:1]));
  assert_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(sp_q) && $stable(st_q)));
endmodule

// File: tb/intr_stack_seq_tb.sv
`timescale 1ns/1ps
module intr_stack_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0] req_lines = 2'b00, op_code = 2'd0;
  logic boundary = 1'b0, op_valid = 1'b0;
  logic [15:0] pc_in = 16'd0;
  logic mem_valid, mem_write, mem_ready, busy, done, pc_load;
  logic [15:0] mem_addr, new_pc;
  logic [7:0] mem_wdata, mem_rdata, status, sp;

  intr_stack_seq u_dut (.*);

  logic [7:0] stk [256];
  logic [7:0] wlog [256];
  logic [15:0] waddr [256];
  logic [7:0] wcnt = 8'd0;
  logic hold = 1'b0, rnd = 1'b0, rbit = 1'b1;
  int n_chk = 0, n_bad = 0;

  logic [7:0] m_stk [256];
  logic [7:0] m_sp, m_st;
  logic [1:0] m_pend, m_line;

  always_comb begin
    if (mem_addr[15:8] == 8'h01) mem_rdata = stk[mem_addr[7:0]];
    else case ({mem_addr[2], mem_addr[0]})
      2'b00: mem_rdata = 8'h23;
      2'b01: mem_rdata = 8'hC1;
      2'b10: mem_rdata = 8'h56;
      default: mem_rdata = 8'hD4;
    endcase
  end
  assign mem_ready = !hold && rbit;

  always @(negedge clk) rbit <= rnd ? ($urandom % 4 != 0) : 1'b1;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) stk[i] <= 8'(i) ^ 8'h5A;
    end else if (mem_valid && mem_ready && mem_write) begin
      stk[mem_addr[7:0]] <= mem_wdata;
      wlog[wcnt] <= mem_wdata;
      waddr[wcnt] <= mem_addr;
      wcnt <= wcnt + 8'd1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_lines(input logic [1:0] v);
    @(negedge clk);
    req_lines = v;
    for (int i = 0; i < 2; i++) if (v[i] != m_line[i]) m_pend[i] = v[i];
    m_line = v;
    @(negedge clk);
  endtask

  task automatic step_boundary(input logic v, input logic [1:0] code, input logic [15:0] pc,
                               input bit cyc_chk, input bit stall);
    int k, cyc, exp_cyc;
    logic [7:0] base, ps;
    logic [15:0] ret, epc;
    @(negedge clk);
    if (m_pend[0] && !m_st[2]) k = 4;
    else if (m_pend[1]) k = 5;
    else if (v) k = int'(code);
    else k = -1;
    boundary = 1'b1; op_valid = v; op_code = code; pc_in = pc; base = wcnt;
    if (stall) hold = 1'b1;
    @(negedge clk);
    boundary = 1'b0; op_valid = 1'b0;
    if (k < 0) begin
      chk("R13 no sequence without op or request", {31'd0, busy}, 32'd0);
      hold = 1'b0;
      return;
    end
    if (k == 4) m_pend[0] = 1'b0;
    if (k == 5) m_pend[1] = 1'b0;
    cyc = 0;
    if (stall) begin
      @(negedge clk); cyc++;
      for (int j = 0; j < 3; j++) begin
        @(negedge clk); cyc++;
        chk("R11 access held while not ready", {31'd0, mem_valid}, 32'd1);
        chk("R11 sp frozen while not ready", {24'd0, sp}, {24'd0, m_sp});
        chk("R11 no write while not ready", {24'd0, wcnt}, {24'd0, base});
      end
      hold = 1'b0;
    end
    while (busy && cyc < 300) begin cyc++; @(negedge clk); end
    chk("R7 done pulse after sequence", {31'd0, done}, 32'd1);
    exp_cyc = (k == 3) ? 6 : (k == 1) ? 3 : (k == 2) ? 4 : 7;
    if (cyc_chk) chk("R7 busy cycle count", cyc, exp_cyc);
    if (k == 0 || k >= 4) begin
      ret = (k == 0) ? pc + 16'd2 : pc;
      ps = {m_st[7:5], k == 0, m_st[3:0]};
      chk("R4 three pushes per entry", {24'd0, wcnt - base}, 32'd3);
      chk("R4 R3 first push high return byte", {8'd0, waddr[base], wlog[base]},
          {8'd0, 8'h01, m_sp, ret[15:8]});
      chk("R4 R3 second push low return byte", {8'd0, waddr[8'(base + 1)], wlog[8'(base + 1)]},
          {8'd0, 8'h01, m_sp - 8'd1, ret[7:0]});
      chk("R5 pushed status and break bit", {8'd0, waddr[8'(base + 2)], wlog[8'(base + 2)]},
          {8'd0, 8'h01, m_sp - 8'd2, ps});
      m_stk[m_sp] = ret[15:8];
      m_stk[m_sp - 8'd1] = ret[7:0];
      m_stk[m_sp - 8'd2] = ps;
      m_sp = m_sp - 8'd3;
      m_st[2] = 1'b1;
      epc = (k == 5) ? 16'hC123 : 16'hD456;
      chk("R6 handler address", {15'd0, pc_load, new_pc}, {15'd0, 1'b1, epc});
      chk("R4 disable flag after entry", {24'd0, status}, {24'd0, m_st});
    end else if (k == 1) begin
      ps = m_st | 8'h10;
      chk("R9 status push data", {8'd0, wcnt - base, wlog[base]}, {8'd0, 8'd1, ps});
      chk("R9 R3 status push address", {16'd0, waddr[base]}, {16'd0, 8'h01, m_sp});
      m_stk[m_sp] = ps;
      m_sp = m_sp - 8'd1;
      chk("R9 no pc load on status push", {31'd0, pc_load}, 32'd0);
    end else if (k == 2) begin
      m_sp = m_sp + 8'd1;
      m_st = m_stk[m_sp] | 8'h20;
      chk("R9 status pull", {23'd0, pc_load, status}, {23'd0, 1'b0, m_st});
      chk("R9 pull writes nothing", {24'd0, wcnt}, {24'd0, base});
    end else begin
      m_st = m_stk[m_sp + 8'd1] | 8'h20;
      epc = {m_stk[m_sp + 8'd3], m_stk[m_sp + 8'd2]};
      m_sp = m_sp + 8'd3;
      chk("R8 return status bit5 forced", {24'd0, status}, {24'd0, m_st});
      chk("R8 return address", {15'd0, pc_load, new_pc}, {15'd0, 1'b1, epc});
    end
    chk("R3 stack pointer", {24'd0, sp}, {24'd0, m_sp});
  endtask

  task automatic finish_up;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog R7 actual=hung expected=finished");
    finish_up();
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < 256; i++) m_stk[i] = 8'(i) ^ 8'h5A;
    m_sp = 8'hFF; m_st = 8'h32; m_pend = 2'b00; m_line = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset sp", {24'd0, sp}, 32'hFF);
    chk("R12 reset status", {24'd0, status}, 32'h32);
    chk("R12 reset idle", {30'd0, busy, mem_valid}, 32'd0);
    step_boundary(1'b0, 2'd0, 16'h1000, 1'b1, 1'b0);
    // R3 wrap: pull at sp FF reads 0x0100, push at sp 00 writes 0x0100
    step_boundary(1'b1, 2'd2, 16'h1000, 1'b1, 1'b0);
    step_boundary(1'b1, 2'd1, 16'h1000, 1'b1, 1'b0);
    step_boundary(1'b1, 2'd0, 16'h2FFF, 1'b1, 1'b0);
    step_boundary(1'b1, 2'd3, 16'h0000, 1'b1, 1'b0);
    step_boundary(1'b1, 2'd2, 16'h0000, 1'b1, 1'b0);
    // R10 R2 both lines rise; op offered in same boundary loses
    if (m_st[2]) begin
      m_stk[m_sp + 8'd1] = 8'h00;
      step_boundary(1'b1, 2'd1, 16'h0000, 1'b1, 1'b0);
    end
    set_lines(2'b11);
    chk("R10 R2 disable flag clear before contest", {31'd0, status[2]}, 32'd0);
    step_boundary(1'b1, 2'd1, 16'h4321, 1'b1, 1'b0);
    step_boundary(1'b0, 2'd0, 16'h5555, 1'b1, 1'b0);
    // R1 masked request waits, op runs instead
    set_lines(2'b00);
    set_lines(2'b01);
    step_boundary(1'b1, 2'd1, 16'h6000, 1'b1, 1'b0);
    step_boundary(1'b1, 2'd3, 16'h6000, 1'b1, 1'b0);
    step_boundary(1'b1, 2'd1, 16'h7000, 1'b0, 1'b1);
    step_boundary(1'b1, 2'd0, 16'h7100, 1'b0, 1'b1);
    rnd = 1'b1;
    for (int it = 0; it < 500; it++) begin
      if ($urandom % 8 < 2) set_lines(2'($urandom % 4));
      else step_boundary(($urandom % 5) != 0, 2'($urandom % 4), 16'($urandom), 1'b0, 1'b0);
    end
    rnd = 1'b0;
    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule